// File: doc/BRIEF.md
# Configuration Frame Error Checker

The checker watches a serial configuration bitstream that arrives one bit per clock, qualified by a valid strobe. It finds frame boundaries in the stream and checks each frame as it passes. A frame opens with a two-bit start marker. Next come `PAYLOAD_BYTES` payload bytes, then one checksum byte, then eight stop bits that must all be 1. While the checker waits for the next start marker, it skips any idle 1s between frames.

Three faults are detected. The first is a corrupt stop run ahead of a start marker. The second is a checksum byte that differs from the XOR of the payload bytes. The third is a device code in the first frame after a restart that does not match the `DEVICE_ID` parameter.

The first fault found is latched as a 2-bit code, and the block then freezes. While frozen it drives its active-low init and interrupt outputs low and ignores the stream. It stays frozen until a reset, a program pulse or a restart command arrives.

Top module: `cfg_frame_checker`

## Requirements
- R1: After reset `err_code` is 00 and both `init_n` and `irq_n` are high.
- R2: While hunting, the bit pair 0 then 1 opens a frame. The payload follows MSB-first and has `PAYLOAD_BYTES` bytes. One checksum byte and eight stop bits come after it. Idle 1s between frames are skipped, and well-formed frames raise no error.
- R3: If the checksum byte differs from the XOR of all payload bytes of its frame, code 11 is latched on the clock edge that takes the checksum's last bit.
- R4: If a start pair completes and any of the eight stop bits of the previous frame was 0, code 10 is latched on the edge that takes the pair's 1 bit. The first frame after reset or restart has no previous stop run and is exempt.
- R5: In the first frame after reset or restart, the first 32 payload bits are compared MSB-first with `DEVICE_ID`. Any difference latches code 01 on the edge that takes the 32nd payload bit, even if the differing bit came earlier. Later frames are not compared.
- R6: Whenever `err_code` is not 00, `init_n` and `irq_n` are both low, and they fall on the same edge that latches the code.
- R7: Only the first error is kept. Once an error is latched, further stream bits change neither the code nor the outputs.
- R8: The error is cleared and the checker returns to hunting with the ID frame expected next under either of two conditions: `prog_n` is low at a clock edge, or `ctrl_we` and `ctrl_restart` are both high at a clock edge. `ctrl_we` alone or `ctrl_restart` alone does nothing.
- R9: Cycles with `bit_valid` low are ignored whatever `bit_in` carries.
- R10: The checksum check covers the ID frame as well: a correct device code with a bad checksum latches code 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_n | input | 1 | Active-low program request, synchronous clear |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_restart | input | 1 | Restart bit of the control write |
| bit_valid | input | 1 | Qualifies `bit_in` |
| bit_in | input | 1 | Serial configuration bit |
| init_n | output | 1 | Low while an error is held |
| irq_n | output | 1 | Active-low error interrupt |
| err_code | output | 2 | 00 none, 01 ID, 10 alignment, 11 checksum |

## Verification
Each error code is registered on the same clock edge that takes the deciding bit. For a checksum fault that bit is the checksum's last bit, for an ID fault it is the 32nd payload bit, and for an alignment fault it is the 1 of the start pair. The bench drives every bit at the falling edge and reads the outputs 1 ns after the rising edge that consumed it. It confirms that the code is still 00 after the bit just before the deciding one and holds the expected code right after it. Clears take effect on the edge that sees the request, and the bench checks them the same way.

// File: rtl/cfg_frame_checker.sv
module cfg_frame_checker #(
  parameter int          PAYLOAD_BYTES = 112,
  parameter int          ID_W          = 32,
  parameter logic [31:0] DEVICE_ID     = 32'h4E4A_17C3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       prog_n,
  input  logic       ctrl_we,
  input  logic       ctrl_restart,
  input  logic       bit_valid,
  input  logic       bit_in,
  output logic       init_n,
  output logic       irq_n,
  output logic [1:0] err_code
);

  localparam int PBITS = PAYLOAD_BYTES * 8;
  localparam int CW    = $clog2(PBITS);
  localparam int NSTOP = 8;

  localparam logic [1:0] E_NONE = 2'b00;
  localparam logic [1:0] E_ID   = 2'b01;
  localparam logic [1:0] E_ALGN = 2'b10;
  localparam logic [1:0] E_SUM  = 2'b11;

  typedef enum logic [2:0] {S_GAP, S_ZERO, S_PAY, S_SUM, S_STOP} st_t;

  st_t             st;
  logic [CW-1:0]   cnt;
  logic [6:0]      sr;
  logic [7:0]      acc;
  logic [ID_W-1:0] id_sh;
  logic            id_ok, first_q, stop_ok;

  wire       clr      = !prog_n || (ctrl_we && ctrl_restart);
  wire       take     = bit_valid && (err_code == E_NONE) && !clr;
  wire [7:0] byte_now = {sr, bit_in};
  wire       byte_end = (cnt[2:0] == 3'd7);
  wire       id_match = id_ok && (bit_in == id_sh[ID_W-1]);

  assign init_n = (err_code == E_NONE);
  assign irq_n  = ~|err_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_GAP;
      cnt      <= '0;
      sr       <= '0;
      acc      <= '0;
      id_sh    <= DEVICE_ID[ID_W-1:0];
      id_ok    <= 1'b1;
      first_q  <= 1'b1;
      stop_ok  <= 1'b1;
      err_code <= E_NONE;
    end else if (clr) begin
      st       <= S_GAP;
      cnt      <= '0;
      sr       <= '0;
      acc      <= '0;
      id_sh    <= DEVICE_ID[ID_W-1:0];
      id_ok    <= 1'b1;
      first_q  <= 1'b1;
      stop_ok  <= 1'b1;
      err_code <= E_NONE;
    end else if (take) begin
      case (st)
        S_GAP: if (!bit_in) st <= S_ZERO;
        S_ZERO: begin
          if (bit_in) begin
            if (!stop_ok) err_code <= E_ALGN;
            else begin
              st    <= S_PAY;
              cnt   <= '0;
              acc   <= '0;
              id_ok <= 1'b1;
              id_sh <= DEVICE_ID[ID_W-1:0];
            end
          end
        end
        S_PAY: begin
          sr    <= byte_now[6:0];
          cnt   <= cnt + 1'b1;
          id_sh <= id_sh << 1;
          id_ok <= id_match;
          if (byte_end) acc <= acc ^ byte_now;
          if (first_q && cnt == CW'(ID_W-1) && !id_match) err_code <= E_ID;
          if (cnt == CW'(PBITS-1)) begin
            st  <= S_SUM;
            cnt <= '0;
          end
        end
        S_SUM: begin
          sr  <= byte_now[6:0];
          cnt <= cnt + 1'b1;
          if (byte_end) begin
            if (byte_now != acc) err_code <= E_SUM;
            else begin
              st      <= S_STOP;
              cnt     <= '0;
              stop_ok <= 1'b1;
              first_q <= 1'b0;
            end
          end
        end
        S_STOP: begin
          cnt     <= cnt + 1'b1;
          stop_ok <= stop_ok & bit_in;
          if (cnt == CW'(NSTOP-1)) st <= S_GAP;
        end
        default: st <= S_GAP;
      endcase
    end
  end

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (err_code == E_NONE && init_n && irq_n));                        // R8
  AST_STICKY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != E_NONE && !clr) |=> $stable(err_code));                     // R7
  AST_ERR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != E_NONE && $past(err_code) == E_NONE) |-> $past(bit_valid)); // R9
  AST_ALIGN_ON_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code == E_ALGN && $past(err_code) == E_NONE) |-> $past(bit_in));    // R4
  AST_ID_FIRST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code == E_ID && $past(err_code) == E_NONE) |-> $past(first_q));     // R5
  AST_OUT_LOW_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|err_code) |-> (!init_n && !irq_n));                               // R6

endmodule

// File: tb/tb_cfg_frame_checker.sv
module tb_cfg_frame_checker;
  localparam int          PB = 6;
  localparam logic [31:0] ID = 32'hC0DE_4E17;

  logic clk = 1'b0, rst_n = 1'b0, prog_n = 1'b1, ctrl_we = 1'b0, ctrl_restart = 1'b0;
  logic bit_valid = 1'b0, bit_in = 1'b1;
  logic init_n, irq_n;
  logic [1:0] err_code;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  logic [7:0] fr [PB];

  always #2 clk = ~clk;

  cfg_frame_checker #(.PAYLOAD_BYTES(PB), .DEVICE_ID(ID)) dut (
    .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .ctrl_we(ctrl_we),
    .ctrl_restart(ctrl_restart), .bit_valid(bit_valid), .bit_in(bit_in),
    .init_n(init_n), .irq_n(irq_n), .err_code(err_code));

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected < 150000", cyc);
      finish_run();
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_err(string req, logic [1:0] e);
    chk(req, {30'd0, err_code}, {30'd0, e});
    chk(req, {31'd0, init_n}, {31'd0, e == 2'b00});
    chk(req, {31'd0, irq_n},  {31'd0, e == 2'b00});
  endtask

  task automatic send_bit(logic b);
    repeat ($urandom_range(0, 3) == 0 ? $urandom_range(1, 3) : 0) begin
      @(negedge clk); bit_valid = 1'b0; bit_in = $urandom;
    end
    @(negedge clk); bit_in = b; bit_valid = 1'b1;
    @(posedge clk); #1; bit_valid = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic send_start(); send_bit(1'b0); send_bit(1'b1); endtask

  task automatic send_stops(int bad);
    for (int i = 0; i < 8; i++) send_bit(i != bad);
  endtask

  function automatic logic [7:0] csum();
    logic [7:0] x = 8'h00;
    for (int i = 0; i < PB; i++) x ^= fr[i];
    return x;
  endfunction

  task automatic fill(bit with_id);
    for (int i = 0; i < PB; i++) fr[i] = $urandom;
    if (with_id) for (int i = 0; i < 4; i++) fr[i] = ID[31-8*i -: 8];
  endtask

  task automatic send_frame(logic [7:0] flip, int bad_stop);
    repeat ($urandom_range(0, 3)) send_bit(1'b1);
    send_start();
    for (int i = 0; i < PB; i++) send_byte(fr[i]);
    send_byte(csum() ^ flip);
    send_stops(bad_stop);
  endtask

  task automatic clear(int how);
    @(negedge clk);
    if (how != 0) prog_n = 1'b0;
    else begin ctrl_we = 1'b1; ctrl_restart = 1'b1; end
    @(posedge clk); #1;
    prog_n = 1'b1; ctrl_we = 1'b0; ctrl_restart = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1789));
    #1; chk_err("R1 reset", 2'b00);
    #9; rst_n = 1'b1;
    @(posedge clk); #1; chk_err("R1 after reset release", 2'b00);

    // R2 R9: ID frame plus data frames, with idle and invalid cycles
    fill(1); send_frame(8'h00, -1); chk_err("R2 good ID frame", 2'b00);
    for (int k = 0; k < 3; k++) begin
      fill(0); send_frame(8'h00, -1); chk_err("R2 R9 good data frame", 2'b00);
    end

    // R3 exact cycle, R6 outputs
    fill(0); send_start();
    for (int i = 0; i < PB; i++) send_byte(fr[i]);
    begin
      logic [7:0] bad = csum() ^ 8'h10;
      for (int i = 7; i >= 1; i--) send_bit(bad[i]);
      chk_err("R3 before last checksum bit", 2'b00);
      send_bit(bad[0]);
      chk_err("R3 R6 checksum error latched", 2'b11);
    end

    // R7: later faults ignored, R8 lone strobes do nothing
    send_stops(2); fill(1); fr[0] ^= 8'h01; send_frame(8'h22, -1);
    chk_err("R7 sticky after more bits", 2'b11);
    @(negedge clk); ctrl_we = 1'b1; @(posedge clk); #1; ctrl_we = 1'b0;
    chk_err("R8 write without restart bit", 2'b11);
    @(negedge clk); ctrl_restart = 1'b1; @(posedge clk); #1; ctrl_restart = 1'b0;
    chk_err("R8 restart bit without write", 2'b11);
    clear(0); chk_err("R8 control restart clears", 2'b00);

    // R5: bad device code in byte 0, flagged at bit 32
    fill(1); fr[0] ^= 8'h80; send_start();
    for (int i = 0; i < 3; i++) send_byte(fr[i]);
    for (int i = 7; i >= 1; i--) send_bit(fr[3][i]);
    chk_err("R5 before 32nd payload bit", 2'b00);
    send_bit(fr[3][0]);
    chk_err("R5 ID mismatch latched", 2'b01);
    clear(1); chk_err("R8 program clears", 2'b00);

    // R5 later frames not compared
    fill(1); send_frame(8'h00, -1);
    fill(0); for (int i = 0; i < 4; i++) fr[i] = ~ID[31-8*i -: 8];
    send_frame(8'h00, -1); chk_err("R5 data frame code ignored", 2'b00);

    // R4: bad stop bit, flagged at the 1 of the next start pair
    fill(0); send_frame(8'h00, 7); chk_err("R4 no error yet", 2'b00);
    send_bit(1'b1); send_bit(1'b0); chk_err("R4 after start 0", 2'b00);
    send_bit(1'b1); chk_err("R4 alignment latched", 2'b10);

    // R4 R8: restart forgets the bad stop run
    fill(1); send_frame(8'h00, 0); clear(0);
    fill(1); send_frame(8'h00, -1); chk_err("R4 first frame exempt", 2'b00);

    // R10: ID frame with bad checksum
    clear(1); fill(1); send_frame(8'h01, -1); chk_err("R10 ID frame checksum", 2'b11);

    // Random frames against a model
    for (int it = 0; it < 40; it++) begin
      logic [1:0] exp = 2'b00;
      clear(it % 2);
      fill(1); send_frame(8'h00, -1); chk_err("R2 random ID frame", 2'b00);
      for (int j = 0; j < 4 && exp == 2'b00; j++) begin
        int kind = $urandom_range(0, 4);
        fill(0);
        if (kind == 0) begin
          send_frame(8'($urandom_range(1, 255)), -1); exp = 2'b11;
          chk_err("R3 random checksum fault", exp);
        end else if (kind == 1) begin
          send_frame(8'h00, $urandom_range(0, 7));
          chk_err("R4 random bad stop pending", 2'b00);
          fill(0); send_frame(8'h00, -1); exp = 2'b10;
          chk_err("R4 R7 random alignment", exp);
        end else begin
          send_frame(8'h00, -1); chk_err("R2 random data frame", 2'b00);
        end
      end
    end
    finish_run();
  end
endmodule